// File: doc/BRIEF.md
# Horizontal Sync Polarity Normalizer

This block takes a raw horizontal sync line of unknown polarity, already in the pixel clock domain, and rebuilds it as a clean sync pulse. It measures how long the input stays high and how long it stays low over each line. It takes the shorter of the two phases as the active pulse and reports that polarity on a status output.

From each leading edge of the active pulse it generates a new pulse. The pulse width, in pixel clocks, comes from a width input, and its polarity comes from a single control bit. The rebuilt pulse is delayed through the same number of register stages as the pixel data path. This keeps it aligned with the data clock and the data words that the rest of the display pipeline uses.

A register stage delay, `PIPE_LAT` (default 4), sets the alignment to the data path. The raw input goes through a two-stage synchronizer before any edge is detected.

Top module: `hsync_normalizer`

## Requirements
- R1: A line runs from one rising edge of the synchronized input to the next. At each such edge `pol_o` becomes 1 when the high phase of the line just ended was shorter than its low phase, and 0 otherwise. `pol_o` resets to 0.
- R2: When `out_pol_i` is 1, `sync_o` is high during a rebuilt pulse and low at other times. When `out_pol_i` is 0, both levels are inverted. During reset `sync_o` holds the idle level that `out_pol_i` selects.
- R3: A rebuilt pulse lasts exactly `width_i` pixel clocks (8 bits, up to 255), whatever the length of the input pulse. It starts at a leading edge: the rising edge when `pol_o` is 1, the falling edge when `pol_o` is 0.
- R4: With default parameters, `sync_o` first shows the active level after the sixth rising clock edge that follows the edge which first samples the raw leading edge. This is two synchronizer stages plus `PIPE_LAT` alignment stages.
- R5: A `width_i` of 0 produces a pulse one pixel clock wide.
- R6: A leading edge that arrives while a pulse is still running restarts the width count. The output then stays active without a gap until `width_i` clocks after the newer edge.
- R7: The raw input passes through two flip-flops before edge detection. A rising edge is recognised only after the input was high two clock edges earlier.
- R8: The first rising edge after reset only starts a measurement and leaves `pol_o` unchanged. The first polarity decision is made at the second rising edge.

Default parameter values are used throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_raw_i | input | 1 | Raw horizontal sync, either polarity |
| out_pol_i | input | 1 | Output polarity: 1 active high, 0 active low |
| width_i | input | 8 | Output pulse width in pixel clocks (0 acts as 1) |
| sync_o | output | 1 | Rebuilt, delay-matched sync |
| pol_o | output | 1 | Detected input polarity: 1 active high, 0 active low |

## Verification
The assertions check four things on every cycle:
- the polarity status changes only in the cycle after a synchronized rising edge;
- a rising edge is flagged only when the raw input was high two edges earlier;
- every leading edge starts or restarts the pulse generator, and a zero width ends the pulse after one cycle;
- the output holds steady while neither the delayed pulse nor the polarity bit moves.

Only the bench's line scenarios can show the end-to-end behaviour:
- the exact latency from the raw edge to the output;
- the full pulse widths, including 255;
- the restart merging two pulses into one;
- the decision that a long high phase means active-low input;
- the ignored first line after reset.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } hs_edge_t;
endpackage

// File: rtl/hs_sync2.sv
module hs_sync2 #(
  parameter int STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            din_i,
  output hs_pkg::hs_edge_t edge_o
);
  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q[g] <= 1'b0;
        else         sr_q[g] <= din_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q[g] <= 1'b0;
        else         sr_q[g] <= sr_q[g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sr_q[STAGES-1];
  end

  assign edge_o.lvl  = sr_q[STAGES-1];
  assign edge_o.rise = sr_q[STAGES-1] & ~prev_q;
  assign edge_o.fall = ~sr_q[STAGES-1] & prev_q;
endmodule

// File: rtl/hs_pol_detect.sv
module hs_pol_detect #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  hs_pkg::hs_edge_t edge_i,
  output logic             pol_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] hi_q, lo_q;
  logic             armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      lo_q    <= '0;
      armed_q <= 1'b0;
      pol_o   <= 1'b0;
    end else if (edge_i.rise) begin
      // line boundary: decide, then restart with this high cycle counted
      if (armed_q) pol_o <= (hi_q < lo_q);
      armed_q <= 1'b1;
      hi_q    <= CNT_W'(1);
      lo_q    <= '0;
    end else if (edge_i.lvl) begin
      if (hi_q != CNT_MAX) hi_q <= hi_q + 1'b1;
    end else begin
      if (lo_q != CNT_MAX) lo_q <= lo_q + 1'b1;
    end
  end
endmodule

// File: rtl/hs_pulse_gen.sv
module hs_pulse_gen #(
  parameter int W_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           lead_i,
  input  logic [W_W-1:0] width_i,
  output logic           act_o
);
  logic [W_W-1:0] cnt_q;
  logic [W_W-1:0] eff_w;

  assign eff_w = (width_i == '0) ? W_W'(1) : width_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_o <= 1'b0;
    end else if (lead_i) begin
      act_o <= 1'b1;
      cnt_q <= eff_w - W_W'(1);
    end else if (act_o) begin
      if (cnt_q == '0) act_o <= 1'b0;
      else             cnt_q <= cnt_q - W_W'(1);
    end
  end
endmodule

// File: rtl/hs_delay.sv
module hs_delay #(
  parameter int DEPTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  output logic dout_o
);
  if (DEPTH == 0) begin : g_pass
    assign dout_o = din_i;
  end else begin : g_pipe
    logic [DEPTH-1:0] sr_q;
    for (genvar g = 0; g < DEPTH; g++) begin : g_st
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     sr_q[g] <= 1'b0;
        else if (g == 0) sr_q[g] <= din_i;
        else             sr_q[g] <= sr_q[(g == 0) ? 0 : g-1];
      end
    end
    assign dout_o = sr_q[DEPTH-1];
  end
endmodule

// File: rtl/hsync_normalizer.sv
module hsync_normalizer #(
  parameter int W_W      = 8,
  parameter int CNT_W    = 12,
  parameter int SYNC_STG = 2,
  parameter int PIPE_LAT = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sync_raw_i,
  input  logic           out_pol_i,
  input  logic [W_W-1:0] width_i,
  output logic           sync_o,
  output logic           pol_o
);
  hs_pkg::hs_edge_t edge_s;
  logic lead, pulse_act, pulse_dly;

  hs_sync2 #(.STAGES(SYNC_STG)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .din_i(sync_raw_i), .edge_o(edge_s)
  );

  hs_pol_detect #(.CNT_W(CNT_W)) u_pol (
    .clk_i(clk_i), .rst_ni(rst_ni), .edge_i(edge_s), .pol_o(pol_o)
  );

  // leading edge of the active phase per detected polarity
  assign lead = pol_o ? edge_s.rise : edge_s.fall;

  hs_pulse_gen #(.W_W(W_W)) u_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .lead_i(lead), .width_i(width_i),
    .act_o(pulse_act)
  );

  hs_delay #(.DEPTH(PIPE_LAT)) u_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .din_i(pulse_act), .dout_o(pulse_dly)
  );

  assign sync_o = out_pol_i ? pulse_dly : ~pulse_dly;
endmodule

// File: rtl/hs_norm_chk.sv
module hs_norm_chk #(
  parameter int W_W = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           sync_raw_i,
  input logic           out_pol_i,
  input logic [W_W-1:0] width_i,
  input logic           sync_o,
  input logic           pol_o,
  input logic           rise_i,
  input logic           lead_i,
  input logic           act_i,
  input logic           dly_i
);
  a_r1_pol_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_o != $past(pol_o)) |-> $past(rise_i));

  a_r7_two_flop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |-> $past(sync_raw_i, 2));

  a_r6_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_i |=> act_i);

  a_r5_zero_is_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(lead_i) && ($past(width_i) == '0) && !lead_i) |=> !act_i);

  a_r2_out_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((out_pol_i == $past(out_pol_i)) && (dly_i == $past(dly_i))) |-> (sync_o == $past(sync_o)));
endmodule

bind hsync_normalizer hs_norm_chk #(.W_W(W_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sync_raw_i(sync_raw_i), .out_pol_i(out_pol_i),
  .width_i(width_i), .sync_o(sync_o), .pol_o(pol_o), .rise_i(edge_s.rise),
  .lead_i(lead), .act_i(pulse_act), .dly_i(pulse_dly)
);

// File: tb/tb_hsync_normalizer.sv
`timescale 1ns/1ps
module tb_hsync_normalizer;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sync_raw_i = 1'b0;
  logic       out_pol_i = 1'b1;
  logic [7:0] width_i = 8'd8;
  logic       sync_o, pol_o;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hsync_normalizer dut (
    .clk_i(clk), .rst_ni(rst_ni), .sync_raw_i(sync_raw_i), .out_pol_i(out_pol_i),
    .width_i(width_i), .sync_o(sync_o), .pol_o(pol_o)
  );

  typedef struct packed {
    logic       in_hi;
    logic [7:0] p;
    logic [7:0] w;
    logic       op;
    logic [7:0] exp_w;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'd8,  8'd16, 1'b1, 8'd16},
    '{1'b1, 8'd8,  8'd16, 1'b0, 8'd16},
    '{1'b0, 8'd10, 8'd5,  1'b1, 8'd5},
    '{1'b0, 8'd10, 8'd5,  1'b0, 8'd5},
    '{1'b1, 8'd3,  8'd0,  1'b1, 8'd1},
    '{1'b0, 8'd20, 8'd40, 1'b1, 8'd40},
    '{1'b1, 8'd1,  8'd1,  1'b0, 8'd1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // caller is at a falling edge; active phase of length p, optional second pulse at q2
  task automatic run_line(input logic hi, input int p, input int l, input int q2,
                          output int first, output int last, output int cnt);
    first = -1; last = -1; cnt = 0;
    sync_raw_i = hi;
    for (int i = 1; i <= l; i++) begin
      @(negedge clk);
      if (sync_o == out_pol_i) begin
        cnt++;
        if (first < 0) first = i;
        last = i;
      end
      if (i == p) sync_raw_i = ~hi;
      if (q2 > 0 && i == q2) sync_raw_i = hi;
      if (q2 > 0 && i == q2 + p) sync_raw_i = ~hi;
    end
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int f, la, c;
    // reset state (R2, R1)
    #10;
    check("R2 reset idle high-pol", int'(sync_o), 0);
    out_pol_i = 1'b0; #1;
    check("R2 reset idle low-pol", int'(sync_o), 1);
    check("R1 reset pol", int'(pol_o), 0);
    out_pol_i = 1'b1;
    @(negedge clk); rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R8: first rising edge only arms the detector
    sync_raw_i = 1'b0; repeat (20) @(negedge clk);
    sync_raw_i = 1'b1; repeat (5) @(negedge clk);
    sync_raw_i = 1'b0; repeat (50) @(negedge clk);
    check("R8 first line ignored", int'(pol_o), 0);
    sync_raw_i = 1'b1; repeat (5) @(negedge clk);
    sync_raw_i = 1'b0; repeat (5) @(negedge clk);
    check("R8 second edge decides", int'(pol_o), 1);
    repeat (80) @(negedge clk);

    // table walk: four lines per vector, measure the fourth
    for (int v = 0; v < NV; v++) begin
      width_i = VECS[v].w;
      out_pol_i = VECS[v].op;
      for (int n = 0; n < 4; n++) run_line(VECS[v].in_hi, VECS[v].p, 100, 0, f, la, c);
      check("R1 detected polarity", int'(pol_o), int'(VECS[v].in_hi));
      check("R4 R7 latency", f, 7);
      check("R3 R5 pulse width", c, int'(VECS[v].exp_w));
      check("R2 pulse contiguous", la - f + 1, int'(VECS[v].exp_w));
    end

    // R6 restart
    width_i = 8'd30; out_pol_i = 1'b1;
    for (int n = 0; n < 3; n++) run_line(1'b1, 4, 100, 0, f, la, c);
    run_line(1'b1, 3, 100, 10, f, la, c);
    check("R6 restart start", f, 7);
    check("R6 restart end", la, 46);
    check("R6 restart count", c, 40);

    // R3 maximum width, active-low output
    width_i = 8'd255; out_pol_i = 1'b0;
    for (int n = 0; n < 3; n++) run_line(1'b1, 4, 300, 0, f, la, c);
    check("R3 width 255", c, 255);
    check("R4 latency 255", f, 7);

    // R1 long high phase means active-low input
    width_i = 8'd4; out_pol_i = 1'b1;
    for (int n = 0; n < 3; n++) run_line(1'b1, 70, 100, 0, f, la, c);
    check("R1 long high -> low pol", int'(pol_o), 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule